// File: doc/BRIEF.md
# UART Byte Echo Core

This block sends every byte it receives on a serial line straight back out. It runs on one system clock. A single divider makes two one-cycle enable pulses: one at the bit rate for the sender and one at eight times the bit rate for the receiver.

The receiver brings the line into the clock domain with two flops. On each oversampling pulse it shifts the line into a short history. It rebuilds frames of one start bit, eight data bits and one stop bit, with no parity. Each finished byte goes into a 16-entry receive queue.

An echo stage moves each byte from the receive queue into a 16-entry transmit queue on the clock after it lands. The sender drains that queue and puts each byte back on the line. While bytes keep coming, the sender chains frames without passing through its idle state. It raises a one-cycle done pulse only when its queue runs dry.

Top module: `uart_echo_core`

## Requirements
- R1: During and after reset, `tx_o` is 1, both empty flags are 1, both overflow flags are 0 and `tx_done_o` is 0.
- R2: Each outgoing frame has the following shape:
  - One low start bit.
  - Eight data bits, least-significant bit first.
  - One high stop bit.
  - Every bit lasts exactly CLK_HZ/BAUD clocks.
  - The line is high between frames.
- R3: Every byte received on `rx_i` is sent on `tx_o` with the same value and in the same order, including 0x00 and 0xFF.
- R4: A start is accepted only after four consecutive low samples at the 8x rate. A low pulse of three samples or fewer produces no frame, and the receiver still takes the next valid frame correctly.
- R5: If another byte is queued when a frame's stop bit is underway, the next start bit follows with no idle gap. Start to start is then exactly 11 bit periods: the stop bit is held for two bit periods.
- R6: `tx_done_o` pulses for exactly one clock each time the sender finishes a frame with its queue empty. In a back-to-back burst it pulses once, after the last frame.
- R7: `tx_overflow_o` sets when an echoed byte meets a full transmit queue, and that byte is dropped. The flag stays set until reset. `rx_overflow_o` stays 0, because the receive queue is drained every clock.
- R8: `rx_empty_o` and `tx_empty_o` return to 1 once every pending byte has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idles high |
| tx_o | output | 1 | Serial transmit line, idles high |
| tx_done_o | output | 1 | One-cycle pulse when the sender drains its queue |
| rx_empty_o | output | 1 | Receive queue holds no byte |
| tx_empty_o | output | 1 | Transmit queue holds no byte |
| rx_overflow_o | output | 1 | Sticky: a write met a full receive queue |
| tx_overflow_o | output | 1 | Sticky: a write met a full transmit queue |

## Verification
Almost any wrong internal state shows up on `tx_o` within one frame time:
- A receiver that samples off mid-bit, or shifts bits the wrong way, sends back a wrong data bit in the echoed frame.
- A divider with the wrong terminal count stretches or shrinks the bit cells.

The reference checks the line against the expected frame on every clock, so a bad bit is caught in the clock where it first appears.

Other faults show on other outputs:
- A sender that returns to idle between queued bytes moves the start-to-start spacing off 11 bit periods.
- A sender that does so also gives an extra done pulse.
- A start qualifier that is too loose turns a short glitch into a frame that nothing expects.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;

    // Sender controller, one-hot
    typedef enum logic [2:0] {
        TX_IDLE = 3'b001,
        TX_WAIT = 3'b010,
        TX_SEND = 3'b100
    } tx_state_e;

    // Receiver controller, one-hot
    typedef enum logic [1:0] {
        RX_IDLE = 2'b01,
        RX_BUSY = 2'b10
    } rx_state_e;

    // Bits needed to hold values 0..v-1, never less than one
    function automatic int unsigned width_of(int unsigned v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_echo_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned BAUD       = 115_200,
    parameter int unsigned OVERSAMPLE = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic rx_stb_o,
    output logic tx_stb_o
);
    localparam int unsigned TX_LAST = CLK_HZ / BAUD - 1;
    localparam int unsigned RX_LAST = CLK_HZ / (BAUD * OVERSAMPLE) - 1;
    localparam int unsigned CNT_W   = width_of(TX_LAST + 1);
    localparam bit          LOCKED  = ((TX_LAST + 1) == OVERSAMPLE * (RX_LAST + 1));

    logic [1:0] stb;

    // lane 0: oversampling enable, lane 1: bit enable
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int unsigned LAST = (g == 0) ? RX_LAST : TX_LAST;
        logic [CNT_W-1:0] cnt_d, cnt_q;

        assign stb[g] = (cnt_q == CNT_W'(LAST));

        always_comb begin
            cnt_d = stb[g] ? '0 : cnt_q + CNT_W'(1);
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) cnt_q <= '0;
            else         cnt_q <= cnt_d;
        end
    end

    assign rx_stb_o = stb[0];
    assign tx_stb_o = stb[1];

    if (TX_LAST > 0) begin : g_chk_width
        // R2: bit enable is a single-clock pulse
        a_r2_tx_strobe_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
            tx_stb_o |=> !tx_stb_o);
    end

    if (LOCKED) begin : g_chk_lock
        // R2: every bit enable coincides with an oversampling enable
        a_r2_strobes_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
            tx_stb_o |-> rx_stb_o);
    end

endmodule

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo
    import uart_echo_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             empty_o,
    output logic             ovf_o
);
    localparam int unsigned PW = width_of(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_t;

    fifo_t            st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             full, take, give;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign take    = push_i && !full;
    assign give    = pop_i && !empty_o;

    always_comb begin
        st_d = st_q;
        if (take) st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + PW'(1);
        if (give) st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + PW'(1);
        case ({take, give})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (push_i && full) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (take) mem_q[st_q.wr] <= wdata_i;
    end

    assign rdata_o = mem_q[st_q.rd];
    assign ovf_o   = st_q.ovf;

    // R7: overflow flag holds until reset
    a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ovf |=> st_q.ovf);
    // R7: a write into a full queue without a read leaves the fill unchanged
    a_r7_full_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && full && !pop_i) |=> $stable(st_q.cnt));
    // R8: fill level never passes the depth
    a_r8_fill_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CW'(DEPTH));

endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_echo_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned OVERSAMPLE = 8,
    parameter int unsigned START_RUN  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rx_i,
    input  logic              smp_stb_i,
    output logic              push_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int unsigned SW = width_of(OVERSAMPLE);
    localparam int unsigned BW = width_of(DATA_W + 1);

    typedef struct packed {
        rx_state_e             st;
        logic [START_RUN-1:0]  hist;
        logic [SW-1:0]         smp;
        logic [BW-1:0]         bits;
        logic [DATA_W-1:0]     shreg;
        logic                  push;
    } rx_t;

    rx_t        st_d, st_q;
    logic [1:0] sync_q;
    logic       line;

    // two-flop synchroniser, idles high
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 2'b11;
        else         sync_q <= {sync_q[0], rx_i};
    end
    assign line = sync_q[1];

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        if (smp_stb_i) begin
            st_d.hist = {st_q.hist[START_RUN-2:0], line};
            case (st_q.st)
                RX_IDLE: begin
                    if (st_d.hist == '0) begin
                        st_d.st   = RX_BUSY;
                        st_d.smp  = '0;
                        st_d.bits = '0;
                    end
                end
                RX_BUSY: begin
                    if (st_q.smp != SW'(OVERSAMPLE - 1)) begin
                        st_d.smp = st_q.smp + SW'(1);
                    end else begin
                        st_d.smp = '0;
                        if (st_q.bits != BW'(DATA_W)) begin
                            st_d.shreg = {line, st_q.shreg[DATA_W-1:1]};
                            st_d.bits  = st_q.bits + BW'(1);
                        end else begin
                            st_d.push = 1'b1;
                            st_d.st   = RX_IDLE;
                        end
                    end
                end
                default: st_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.st    <= RX_IDLE;
            st_q.hist  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign push_o = st_q.push;
    assign data_o = st_q.shreg;

    // R4: a frame is entered only with a fully low history
    a_r4_start_needs_low_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.st == RX_BUSY) |-> (st_q.hist == '0));
    // R3: each byte is handed over in a single clock
    a_r3_push_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.push |=> !st_q.push);
    // R4: controller stays one-hot
    a_r4_state_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(st_q.st));

endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_echo_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bit_stb_i,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    output logic              pop_o,
    output logic              tx_o,
    output logic              done_o
);
    localparam int unsigned CW = width_of(DATA_W + 2);

    typedef struct packed {
        tx_state_e         st;
        logic [DATA_W:0]   shreg;
        logic [CW-1:0]     bits;
        logic [DATA_W-1:0] hold;
        logic              done;
    } tx_t;

    tx_t  st_d, st_q;
    logic last;

    assign last = (st_q.bits == CW'(DATA_W + 1));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        pop_o     = 1'b0;
        if (bit_stb_i) begin
            case (st_q.st)
                TX_IDLE: begin
                    if (!fifo_empty_i) begin
                        pop_o     = 1'b1;
                        st_d.hold = fifo_data_i;
                        st_d.st   = TX_WAIT;
                    end
                end
                TX_WAIT: begin
                    st_d.shreg = {st_q.hold, 1'b0};
                    st_d.st    = TX_SEND;
                end
                TX_SEND: begin
                    if (!last) begin
                        st_d.shreg = {1'b1, st_q.shreg[DATA_W:1]};
                        st_d.bits  = st_q.bits + CW'(1);
                    end else begin
                        st_d.bits = '0;
                        if (!fifo_empty_i) begin
                            pop_o     = 1'b1;
                            st_d.hold = fifo_data_i;
                            st_d.st   = TX_WAIT;
                        end else begin
                            st_d.done = 1'b1;
                            st_d.st   = TX_IDLE;
                        end
                    end
                end
                default: st_d.st = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.st    <= TX_IDLE;
            st_q.shreg <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_o   = st_q.shreg[0];
    assign done_o = st_q.done;

    // R1: line is high whenever the sender is idle
    a_r1_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.st == TX_IDLE) |-> tx_o);
    // R5: controller stays one-hot
    a_r5_state_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(st_q.st));
    // R6: done coincides with arrival in idle and lasts one clock
    a_r6_done_in_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (st_q.st == TX_IDLE));
    a_r6_done_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R2: bit counter never passes the frame length
    a_r2_bits_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.bits <= CW'(DATA_W + 1));

endmodule

// File: rtl/uart_echo_core.sv
module uart_echo_core
    import uart_echo_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned BAUD       = 115_200,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned OVERSAMPLE = 8,
    parameter int unsigned START_RUN  = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rx_i,
    output logic tx_o,
    output logic tx_done_o,
    output logic rx_empty_o,
    output logic tx_empty_o,
    output logic rx_overflow_o,
    output logic tx_overflow_o
);
    logic              rx_stb, tx_stb;
    logic              rx_push;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] rxq_data, txq_data;
    logic              rxq_empty, txq_empty;
    logic              echo_mv, tx_pop;

    uart_baud_gen #(
        .CLK_HZ    (CLK_HZ),
        .BAUD      (BAUD),
        .OVERSAMPLE(OVERSAMPLE)
    ) i_baud (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rx_stb_o(rx_stb),
        .tx_stb_o(tx_stb)
    );

    uart_rx #(
        .DATA_W    (DATA_W),
        .OVERSAMPLE(OVERSAMPLE),
        .START_RUN (START_RUN)
    ) i_rx (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rx_i     (rx_i),
        .smp_stb_i(rx_stb),
        .push_o   (rx_push),
        .data_o   (rx_byte)
    );

    uart_sync_fifo #(
        .WIDTH(DATA_W),
        .DEPTH(FIFO_DEPTH)
    ) i_rx_q (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (rx_push),
        .wdata_i(rx_byte),
        .pop_i  (echo_mv),
        .rdata_o(rxq_data),
        .empty_o(rxq_empty),
        .ovf_o  (rx_overflow_o)
    );

    // echo stage: any byte waiting in the receive queue moves over at once
    assign echo_mv = !rxq_empty;

    uart_sync_fifo #(
        .WIDTH(DATA_W),
        .DEPTH(FIFO_DEPTH)
    ) i_tx_q (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (echo_mv),
        .wdata_i(rxq_data),
        .pop_i  (tx_pop),
        .rdata_o(txq_data),
        .empty_o(txq_empty),
        .ovf_o  (tx_overflow_o)
    );

    uart_tx #(
        .DATA_W(DATA_W)
    ) i_tx (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bit_stb_i   (tx_stb),
        .fifo_empty_i(txq_empty),
        .fifo_data_i (txq_data),
        .pop_o       (tx_pop),
        .tx_o        (tx_o),
        .done_o      (tx_done_o)
    );

    assign rx_empty_o = rxq_empty;
    assign tx_empty_o = txq_empty;

    // R7: the receive queue is drained every clock, so it never overflows
    a_r7_rx_queue_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_overflow_o);
    // R3: a byte written into the receive queue has left it one clock later
    a_r3_echo_next_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_push && rxq_empty) |=> (!rxq_empty && echo_mv));
    // R5: the sender only takes bytes on a bit enable
    a_r5_pop_on_bit_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_pop |-> (tx_stb && !txq_empty));

endmodule

// File: tb/test_uart_echo_core.sv
`timescale 1ns/1ps
module test_uart_echo_core;
    localparam int unsigned CLK_HZ   = 1_600_000;
    localparam int unsigned BAUD     = 100_000;
    localparam int          BIT_CLKS = CLK_HZ / BAUD;
    localparam int          FRAME    = 10 * BIT_CLKS;
    localparam int          CHAIN    = 11 * BIT_CLKS;
    localparam int          WATCHDOG = 190_000;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic rx    = 1'b1;
    logic tx, done, rx_empty, tx_empty, rx_ovf, tx_ovf;

    uart_echo_core #(
        .CLK_HZ(CLK_HZ),
        .BAUD  (BAUD)
    ) i_uart_echo_core (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .rx_i         (rx),
        .tx_o         (tx),
        .tx_done_o    (done),
        .rx_empty_o   (rx_empty),
        .tx_empty_o   (tx_empty),
        .rx_overflow_o(rx_ovf),
        .tx_overflow_o(tx_ovf)
    );

    always #2.5 clk = ~clk;

    int         checks   = 0;
    int         fails    = 0;
    int         cyc      = 0;
    int         done_cnt = 0;
    bit         mon_en   = 0;
    bit         mon_act  = 0;
    bit         finished = 0;
    int         mon_c    = 0;
    logic [7:0] mon_b    = '0;
    logic [7:0] exp_q[$];
    int         starts[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // reference model: expected line level on every clock of every frame
    always @(negedge clk) begin
        cyc++;
        if (rst_n && done) done_cnt++;
        if (!mon_en || !rst_n) begin
            mon_act = 0;
        end else begin
            if (!mon_act && tx == 1'b0) begin
                starts.push_back(cyc);
                if (exp_q.size() == 0) begin
                    chk(0, "R3 unexpected frame", 1, 0);
                    mon_b = '0;
                end else begin
                    mon_b = exp_q.pop_front();
                end
                mon_act = 1;
                mon_c   = 0;
            end
            if (mon_act) begin
                int   bitn;
                logic expb;
                bitn = mon_c / BIT_CLKS;
                if (bitn == 0)      expb = 1'b0;
                else if (bitn == 9) expb = 1'b1;
                else                expb = mon_b[bitn-1];
                chk(tx === expb, (bitn >= 1 && bitn <= 8) ? "R3 data bit" : "R2 framing bit",
                    int'(tx), int'(expb));
                mon_c++;
                if (mon_c == FRAME) mon_act = 0;
            end
        end
        if (cyc > WATCHDOG && !finished) begin
            fails++;
            $display("FAIL watchdog R1..: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            summary();
        end
    end

    task automatic send(input logic [7:0] b, input bit track);
        if (track) exp_q.push_back(b);
        for (int i = 0; i < 10; i++) begin
            rx = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
            repeat (BIT_CLKS) @(negedge clk);
        end
    endtask

    task automatic echo_one(input logic [7:0] b);
        int d0;
        d0 = done_cnt;
        send(b, 1);
        repeat (300) @(negedge clk);
        chk(exp_q.size() == 0, "R3 byte echoed", exp_q.size(), 0);
        chk(done_cnt - d0 == 1, "R6 one done pulse", done_cnt - d0, 1);
        chk(rx_empty && tx_empty, "R8 queues empty", {rx_empty, tx_empty}, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk(tx == 1'b1, "R1 tx high in reset", tx, 1);
        chk(rx_empty && tx_empty, "R1 empty in reset", {rx_empty, tx_empty}, 3);
        chk(!rx_ovf && !tx_ovf, "R1 no overflow in reset", {rx_ovf, tx_ovf}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx == 1'b1 && done == 1'b0, "R1 idle after reset", {tx, done}, 2);
        mon_en = 1;

        // R2, R3, R6: isolated bytes with varied patterns
        echo_one(8'hA5);
        echo_one(8'h00);
        echo_one(8'hFF);
        echo_one(8'h01);
        echo_one(8'h80);
        echo_one(8'h3C);

        // R5: back-to-back burst chains frames
        begin
            int d0;
            starts.delete();
            d0 = done_cnt;
            send(8'h11, 1); send(8'h22, 1); send(8'hEE, 1);
            send(8'h7F, 1); send(8'hFE, 1); send(8'h96, 1);
            repeat (6 * CHAIN + 400) @(negedge clk);
            chk(starts.size() == 6, "R3 burst frame count", starts.size(), 6);
            for (int i = 1; i < starts.size(); i++)
                chk(starts[i] - starts[i-1] == CHAIN, "R5 start spacing",
                    starts[i] - starts[i-1], CHAIN);
            chk(done_cnt - d0 == 1, "R6 single done per burst", done_cnt - d0, 1);
            chk(exp_q.size() == 0, "R3 burst all echoed", exp_q.size(), 0);
            chk(rx_empty && tx_empty, "R8 queues empty after burst", {rx_empty, tx_empty}, 3);
        end

        // R4: a 3-sample low glitch is rejected
        begin
            int n;
            n = starts.size();
            rx = 1'b0;
            repeat (6) @(negedge clk);
            rx = 1'b1;
            repeat (400) @(negedge clk);
            chk(starts.size() == n, "R4 glitch gave no frame", starts.size(), n);
            chk(rx_empty && tx_empty, "R4 nothing queued", {rx_empty, tx_empty}, 3);
            echo_one(8'h5A);
        end

        // R7: sustained input outruns the chained sender
        mon_en = 0;
        for (int i = 0; i < 260; i++) send(8'(i), 0);
        chk(tx_ovf == 1'b1, "R7 tx overflow set", tx_ovf, 1);
        chk(rx_ovf == 1'b0, "R7 rx never overflows", rx_ovf, 0);
        repeat (1000) @(negedge clk);
        chk(tx_ovf == 1'b1, "R7 overflow sticky", tx_ovf, 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!tx_ovf && !rx_ovf && tx == 1'b1, "R1 reset clears overflow", {tx_ovf, rx_ovf, tx}, 1);
        chk(rx_empty && tx_empty, "R1 reset empties queues", {rx_empty, tx_empty}, 3);
        rst_n = 1'b1;
        exp_q.delete();
        repeat (4) @(negedge clk);
        mon_en = 1;
        echo_one(8'hC3);

        summary();
    end
endmodule